// File: doc/BRIEF.md
# Airtime Duration Calculator

This block works out how long an OFDM frame holds the medium and the inter-frame timing that goes with it. A request carries the frame length in bytes, the bitrate in 100 kbps units, a channel-width mode and a coverage class. The block captures these inputs when it accepts the request. It returns the frame duration in microseconds, together with the slot time and the ACK and CTS timeouts, and raises a one-cycle done pulse when they are ready.

The channel-width mode sets the preamble time, the symbol time and the SIFS. In the narrow modes it also slows the bitrate before the symbol count is taken. The symbol count is a ceiling division, which a bit-serial divider computes over several cycles. The slot time grows by 3 µs for each coverage-class step. Both timeouts are the mode SIFS plus that slot time. A timeout that does not fit its output field is flagged and does not replace the previous timeout.

Top module: `airtime_calc`

## Requirements
- R1: After reset, busy, done, to_err, duration, slot_time, ack_timeout and cts_timeout are all zero.
- R2: Mode code 0 (default) uses SIFS 16, preamble 20, symbol 4 and slot 9. Duration = SIFS + preamble + symbol × ceil(((22 + 8 × len) × 10) / (rate × symbol)).
- R3: Mode code 1 (40 MHz) uses SIFS 8, preamble 14, symbol 4 and slot 6, and leaves the bitrate unchanged.
- R4: Mode code 2 (10 MHz) uses preamble 40 and symbol 8, the SIFS_HALF and SLOT_HALF parameters (32 and 13 by default), and a bitrate of ceil(rate / 2).
- R5: Mode code 3 (5 MHz) uses preamble 80 and symbol 16, the SIFS_QTR and SLOT_QTR parameters (64 and 21 by default), and a bitrate of ceil(rate / 4).
- R6: The symbol count is rounded up when the division leaves a remainder. It is not increased when the division is exact.
- R7: slot_time = mode slot + 3 × cov_class.
- R8: ack_timeout and cts_timeout both equal mode SIFS + slot_time.
- R9: When mode SIFS + slot_time exceeds 2^TO_W − 1 (255 by default), to_err is set and both timeouts keep their previous values, while slot_time and duration still update. The next result whose timeout fits clears to_err.
- R10: A start request while busy is high is ignored. Input changes during a computation do not affect its result.
- R11: done is high for exactly one cycle. With default parameters it is first sampled high 22 rising edges after the edge that accepted start, and busy is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request; accepted when busy is low |
| len_bytes | input | LEN_W | Frame length in bytes |
| rate | input | RATE_W | Bitrate in 100 kbps units, nonzero |
| bw_mode | input | 2 | 0 default, 1 40 MHz, 2 10 MHz, 3 5 MHz |
| cov_class | input | CC_W | Coverage class |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| duration | output | LEN_W+14 | Frame airtime in µs |
| slot_time | output | CC_W+4 | Adjusted slot time in µs |
| ack_timeout | output | TO_W | ACK timeout in µs |
| cts_timeout | output | TO_W | CTS timeout in µs |
| to_err | output | 1 | Last timeout did not fit its field |

## Verification
The hardest case to reach from the ports is the overflow path of R9. An overflowing result does not change the timeout outputs, so the check only means something once a distinct good timeout has been stored first. The stimulus runs a narrow-mode request with coverage class 70, which gives a timeout of exactly 255 and sits on the field limit. Class 71 follows, and the bench checks that 255 is still held. A second hard case is a start request that lands mid-computation with different operands. The bench injects it a few cycles after acceptance and holds the new operands until done, then checks that the result matches the first request.

// File: rtl/airtime_calc.sv
module airtime_calc #(
  parameter int LEN_W     = 12,
  parameter int RATE_W    = 10,
  parameter int CC_W      = 8,
  parameter int TO_W      = 8,
  parameter int SIFS_HALF = 32,
  parameter int SIFS_QTR  = 64,
  parameter int SLOT_HALF = 13,
  parameter int SLOT_QTR  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len_bytes,
  input  logic [RATE_W-1:0] rate,
  input  logic [1:0]        bw_mode,
  input  logic [CC_W-1:0]   cov_class,
  output logic              busy,
  output logic              done,
  output logic [LEN_W+13:0] duration,
  output logic [CC_W+3:0]   slot_time,
  output logic [TO_W-1:0]   ack_timeout,
  output logic [TO_W-1:0]   cts_timeout,
  output logic              to_err
);
  localparam int NUM_W = LEN_W + 8;
  localparam int DVD_W = NUM_W + 1;
  localparam int DEN_W = RATE_W + 5;
  localparam int DUR_W = LEN_W + 14;
  localparam int SL_W  = CC_W + 4;
  localparam int CNT_W = $clog2(DVD_W + 1);
  localparam logic [SL_W-1:0] TO_MAX = SL_W'((1 << TO_W) - 1);

  function automatic int sifs_of(input logic [1:0] m);
    case (m)
      2'd1: return 8;
      2'd2: return SIFS_HALF;
      2'd3: return SIFS_QTR;
      default: return 16;
    endcase
  endfunction

  function automatic int pre_of(input logic [1:0] m);
    case (m)
      2'd1: return 14;
      2'd2: return 40;
      2'd3: return 80;
      default: return 20;
    endcase
  endfunction

  function automatic int sym_of(input logic [1:0] m);
    case (m)
      2'd2: return 8;
      2'd3: return 16;
      default: return 4;
    endcase
  endfunction

  function automatic int slot_of(input logic [1:0] m);
    case (m)
      2'd1: return 6;
      2'd2: return SLOT_HALF;
      2'd3: return SLOT_QTR;
      default: return 9;
    endcase
  endfunction

  logic [RATE_W:0]  rate_eff;
  logic [1:0]       mode_q;
  logic [CC_W-1:0]  cc_q;
  logic [DEN_W-1:0] den_q;
  logic [DEN_W-1:0] acc;
  logic [DVD_W-1:0] qr;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    case (bw_mode)
      2'd2:    rate_eff = ({1'b0, rate} + (RATE_W+1)'(1)) >> 1;
      2'd3:    rate_eff = ({1'b0, rate} + (RATE_W+1)'(3)) >> 2;
      default: rate_eff = {1'b0, rate};
    endcase
  end

  wire [DEN_W-1:0] den_c  = DEN_W'(rate_eff) * DEN_W'(sym_of(bw_mode));
  wire [DVD_W-1:0] bits_c = DVD_W'(22) + DVD_W'({len_bytes, 3'b000});
  wire [DVD_W-1:0] dvd_c  = bits_c * DVD_W'(10) + DVD_W'(den_c) - DVD_W'(1);

  wire [DEN_W:0] trial = {acc, qr[DVD_W-1]};
  wire           ge    = trial >= {1'b0, den_q};
  wire [DEN_W:0] diff  = trial - {1'b0, den_q};

  wire [SL_W-1:0]  slot_n = SL_W'(slot_of(mode_q)) + SL_W'(3) * SL_W'(cc_q);
  wire [SL_W-1:0]  to_n   = slot_n + SL_W'(sifs_of(mode_q));
  wire [DUR_W-1:0] dur_n  = DUR_W'(sifs_of(mode_q)) + DUR_W'(pre_of(mode_q))
                          + DUR_W'(sym_of(mode_q)) * DUR_W'(qr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; to_err <= 1'b0;
      mode_q <= '0; cc_q <= '0; den_q <= '0; acc <= '0; qr <= '0; cnt <= '0;
      duration <= '0; slot_time <= '0; ack_timeout <= '0; cts_timeout <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          mode_q <= bw_mode;
          cc_q   <= cov_class;
          den_q  <= den_c;
          qr     <= dvd_c;
          acc    <= '0;
          cnt    <= CNT_W'(DVD_W);
        end
      end else if (cnt != '0) begin
        acc <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        qr  <= {qr[DVD_W-2:0], ge};
        cnt <= cnt - CNT_W'(1);
      end else begin
        busy      <= 1'b0;
        done      <= 1'b1;
        duration  <= dur_n;
        slot_time <= slot_n;
        if (to_n > TO_MAX) begin
          to_err <= 1'b1;
        end else begin
          to_err      <= 1'b0;
          ack_timeout <= to_n[TO_W-1:0];
          cts_timeout <= to_n[TO_W-1:0];
        end
      end
    end
  end

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  a_r10_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> busy);
  a_r9_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && to_err) |-> ($stable(ack_timeout) && $stable(cts_timeout)));
  a_r8_to_above_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !to_err) |-> (SL_W'(ack_timeout) > slot_time));
  a_r7_slot_floor: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (slot_time >= SL_W'(6)));
endmodule

// File: tb/sim_airtime_calc.sv
module sim_airtime_calc;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] len_bytes = '0;
  logic [9:0]  rate = '0;
  logic [1:0]  bw_mode = '0;
  logic [7:0]  cov_class = '0;
  logic        busy, done, to_err;
  logic [25:0] duration;
  logic [11:0] slot_time;
  logic [7:0]  ack_timeout, cts_timeout;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  longint last_to = 0;

  airtime_calc u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .len_bytes(len_bytes), .rate(rate),
    .bw_mode(bw_mode), .cov_class(cov_class), .busy(busy), .done(done),
    .duration(duration), .slot_time(slot_time), .ack_timeout(ack_timeout),
    .cts_timeout(cts_timeout), .to_err(to_err)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint sifs_e(input int m);
    return (m == 1) ? 8 : (m == 2) ? 32 : (m == 3) ? 64 : 16;
  endfunction
  function automatic longint slot_e(input int m);
    return (m == 1) ? 6 : (m == 2) ? 13 : (m == 3) ? 21 : 9;
  endfunction
  function automatic longint dur_e(input longint len, input longint r, input int m);
    longint pre, sym, re, q;
    pre = (m == 1) ? 14 : (m == 2) ? 40 : (m == 3) ? 80 : 20;
    sym = (m == 2) ? 8 : (m == 3) ? 16 : 4;
    re  = (m == 2) ? (r + 1) / 2 : (m == 3) ? (r + 3) / 4 : r;
    q   = ((22 + 8 * len) * 10 + re * sym - 1) / (re * sym);
    return sifs_e(m) + pre + sym * q;
  endfunction

  task automatic kick(input int len, input int r, input int m, input int cc, output int lat);
    @(negedge clk);
    len_bytes = 12'(len); rate = 10'(r); bw_mode = 2'(m); cov_class = 8'(cc); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat = lat + 1;
    end
  endtask

  task automatic run_case(input string tag, input int len, input int r, input int m, input int cc);
    int lat;
    longint to;
    kick(len, r, m, cc, lat);
    to = sifs_e(m) + slot_e(m) + 3 * cc;
    chk({tag, " duration"}, duration, dur_e(len, r, m));
    chk("R7 slot_time", slot_time, slot_e(m) + 3 * cc);
    if (to <= 255) begin
      chk("R8 ack_timeout", ack_timeout, to);
      chk("R8 cts_timeout", cts_timeout, to);
      chk("R9 to_err clear", to_err, 0);
      last_to = to;
    end else begin
      chk("R9 to_err set", to_err, 1);
      chk("R9 ack held", ack_timeout, last_to);
      chk("R9 cts held", cts_timeout, last_to);
    end
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 to_err", to_err, 0);
    chk("R1 duration", duration, 0);
    chk("R1 slot", slot_time, 0);
    chk("R1 ack", ack_timeout, 0);
    chk("R1 cts", cts_timeout, 0);
  endtask

  task automatic t_latency();
    int lat;
    kick(10, 60, 0, 0, lat);
    chk("R11 latency", lat, 22);
    chk("R11 busy low at done", busy, 0);
    @(negedge clk);
    chk("R11 done one cycle", done, 0);
    chk("R2 duration", duration, 56);
  endtask

  task automatic t_ignore();
    int lat;
    @(negedge clk);
    len_bytes = 12'd100; rate = 10'd90; bw_mode = 2'd3; cov_class = 8'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    len_bytes = 12'd1500; rate = 10'd540; bw_mode = 2'd1; cov_class = 8'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat = lat + 1;
    end
    chk("R10 duration of first request", duration, 512);
    chk("R10 slot of first request", slot_time, 27);
    chk("R10 ack of first request", ack_timeout, 91);
    last_to = 91;
    @(negedge clk);
    chk("R10 no second result", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_latency();
    run_case("R2", 1500, 540, 0, 0);
    run_case("R6 exact", 1, 15, 0, 0);
    chk("R6 exact value", duration, 56);
    run_case("R6 remainder", 2, 15, 0, 1);
    run_case("R3", 1500, 540, 1, 0);
    chk("R3 value", duration, 246);
    run_case("R4", 10, 60, 2, 3);
    chk("R4 value", duration, 112);
    run_case("R4 odd rate", 50, 9, 2, 0);
    run_case("R5", 100, 90, 3, 2);
    chk("R5 value", duration, 512);
    run_case("R5 rate 1", 4, 1, 3, 0);
    run_case("R9 limit", 200, 120, 2, 70);
    chk("R9 limit ack", ack_timeout, 255);
    run_case("R9 over", 200, 120, 2, 71);
    run_case("R9 over default", 20, 240, 0, 80);
    run_case("R9 recover", 20, 240, 0, 76);
    t_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule